// File: doc/BRIEF.md
# PCI Target Inbound Command Handler

This block sits behind the address-phase capture stage of a PCI target. Each time the capture stage presents a one-cycle strobe with the latched 4-bit command, the address, the active-low byte enables and the first data word, the handler decides whether to claim or ignore the transaction. It applies the target-side support rules. Legacy commands and reserved codes are refused. Configuration accesses are gated by an agent-mode strap and the select line.

An accepted command becomes one or more requests on a local channel with a valid/ready handshake:
- Reads of prefetchable memory become 32-byte line fetches.
- The multiple-read command adds a fetch of the following line.
- Writes that enable fewer than four byte lanes are split into single-byte writes, one per enabled lane, in ascending lane order.

A dual address cycle is claimed and holds the low address half. The next strobe then supplies the upper half and the real command, and the two halves form a 64-bit local address.

The capture stage presents a new strobe only after the previous one has been answered by `claim` or `ignore`. If the command was claimed and started a local access, it also waits for `done`.

Top module: `pci_tgt_cmd_handler`

## Requirements
- R1: Command codes 0100, 0101, 1000 and 1001 are reserved. They produce an `ignore` pulse, no `claim`, no local request and no `done`.
- R2: Codes 0000 to 0011 (interrupt acknowledge, special cycle, I/O read, I/O write) are ignored in the same way as reserved codes.
- R3: Configuration read (1010) and write (1011) are claimed only while `agent_mode` and `cap_idsel` are both 1; otherwise they are ignored. A claimed configuration read issues one word read with `lreq_cfg`=1.
- R4: One cycle after an accepted strobe, exactly one of `claim` or `ignore` pulses for one cycle.
- R5: `lreq_size` encodes 0 = byte, 1 = word, 2 = line of 32 bytes. Word and line addresses have bits [1:0] cleared. Memory read (0110) with `cap_prefetch`=1 issues one line read; with `cap_prefetch`=0 it issues one word read.
- R6: Memory read line (1110) always issues one line read.
- R7: Memory read multiple (1100) issues a line read at the given address, then a line read at the 32-byte-aligned base plus 32.
- R8: A write (0111, 1111, or a claimed 1011) with `cap_be_n`=0000 issues one word write carrying `cap_wdata`.
- R9: A write with some but not all lanes enabled (a lane is enabled when its `cap_be_n` bit is 0) issues one byte write per enabled lane, lane 0 first. Each has address = word base + lane, with the lane's byte in `lreq_data[7:0]` and upper bits zero.
- R10: A write with `cap_be_n`=1111 is claimed, issues no local request, and pulses `done` in the cycle after the strobe.
- R11: A request holds all its fields stable until `lreq_ready`. `done` pulses for one cycle, the cycle after the last request is accepted, and never together with `lreq_valid`.
- R12: Write-and-invalidate (1111) pulses `inval_valid` with `claim`, carrying the 32-byte-aligned line address on `inval_addr`.
- R13: Dual address cycle (1101) is claimed with no request and no `done`. The next strobe's `cap_addr` becomes address bits [63:32] over the stored low half. A second 1101 while one is pending is ignored and clears the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agent_mode | input | 1 | Strap: configuration accesses may be claimed |
| cap_valid | input | 1 | One-cycle strobe of a captured address phase |
| cap_cmd | input | 4 | Captured command code |
| cap_addr | input | 32 | Captured address |
| cap_be_n | input | 4 | Active-low byte enables |
| cap_wdata | input | 32 | First write data word |
| cap_idsel | input | 1 | Select line for configuration accesses |
| cap_prefetch | input | 1 | Address lies in prefetchable space |
| claim | output | 1 | Pulse: transaction claimed |
| ignore | output | 1 | Pulse: transaction not responded to |
| inval_valid | output | 1 | Pulse: line invalidate request |
| inval_addr | output | 64 | Line-aligned invalidate address |
| lreq_valid | output | 1 | Local request valid |
| lreq_ready | input | 1 | Local request accepted |
| lreq_write | output | 1 | Local request is a write |
| lreq_cfg | output | 1 | Local request targets configuration space |
| lreq_size | output | 2 | 0 byte, 1 word, 2 line |
| lreq_addr | output | 64 | Local request address |
| lreq_data | output | 32 | Write data (byte in [7:0] for byte writes) |
| done | output | 1 | Pulse: last local request completed |

## Verification
The checker watches, on every cycle, that reserved codes, legacy commands and ungated configuration accesses draw `ignore`, and that every claim or ignore follows an accepted strobe. It also watches that a waiting request never changes, that `done` never overlaps a request, and that line requests are word-aligned reads while byte requests are writes with clean upper data. Only the bench scenarios can show that the right sequence of requests appears: the ordering of split byte lanes, the second line of a multiple read, the join of the two address halves after a dual address cycle, and the empty write that completes with no access.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LINE = 2'd2
  } lsize_e;

  typedef enum logic [3:0] {
    K_IGNORE,
    K_DAC,
    K_RD_WORD,
    K_RD_LINE,
    K_RD_TWO,
    K_WR,
    K_WR_INV,
    K_CFG_RD,
    K_CFG_WR
  } kind_e;

  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [3:0] CMD_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_DUAL    = 4'b1101;
  localparam logic [3:0] CMD_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_WR_INV  = 4'b1111;

endpackage

// File: rtl/pci_tgt_cmd_decode.sv
module pci_tgt_cmd_decode
  import pci_tgt_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic       idsel,
  input  logic       agent_mode,
  input  logic       prefetch,
  input  logic       dual_pend,
  output kind_e      kind
);

  always_comb begin
    kind = K_IGNORE;
    case (cmd)
      CMD_MEM_RD:  kind = prefetch ? K_RD_LINE : K_RD_WORD;
      CMD_MEM_WR:  kind = K_WR;
      CMD_CFG_RD:  kind = (agent_mode && idsel) ? K_CFG_RD : K_IGNORE;
      CMD_CFG_WR:  kind = (agent_mode && idsel) ? K_CFG_WR : K_IGNORE;
      CMD_RD_MULT: kind = K_RD_TWO;
      CMD_DUAL:    kind = dual_pend ? K_IGNORE : K_DAC;
      CMD_RD_LINE: kind = K_RD_LINE;
      CMD_WR_INV:  kind = K_WR_INV;
      default:     kind = K_IGNORE;
    endcase
  end

endmodule

// File: rtl/pci_tgt_lane_pick.sv
module pci_tgt_lane_pick #(
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] first_oh,
  output logic [IDX_W-1:0] first_idx
);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
        assign first_oh[g] = mask[g];
      end else begin : g_up
        assign first_oh[g] = mask[g] & ~(|mask[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    first_idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (first_oh[i]) first_idx = first_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/pci_tgt_req_seq.sv
module pci_tgt_req_seq
  import pci_tgt_pkg::*;
#(
  parameter int PCI_AW     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LA_W       = 2 * PCI_AW,
  parameter int LANES      = PCI_AW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  kind_e             kind,
  input  logic [LA_W-1:0]   addr,
  input  logic [LANES-1:0]  be_n,
  input  logic [PCI_AW-1:0] wdata,
  input  logic              lreq_ready,
  output logic              lreq_valid,
  output logic              lreq_write,
  output logic              lreq_cfg,
  output logic [1:0]        lreq_size,
  output logic [LA_W-1:0]   lreq_addr,
  output logic [PCI_AW-1:0] lreq_data,
  output logic              done,
  output logic              idle
);

  localparam int IDX_W    = $clog2(LANES);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_FIN} st_e;

  st_e               st_q, st_d;
  logic [LA_W-1:0]   addr_q, addr_d;
  logic              write_q, write_d;
  logic              cfg_q, cfg_d;
  lsize_e            size_q, size_d;
  logic [LANES-1:0]  lanes_q, lanes_d;
  logic              two_q, two_d;
  logic [PCI_AW-1:0] data_q, data_d;

  logic [LANES-1:0]  pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic              fire;
  logic              op_en;
  logic [LA_W-1:0]   next_line;

  pci_tgt_lane_pick #(.LANES(LANES), .IDX_W(IDX_W)) u_pick (
    .mask      (lanes_q),
    .first_oh  (pick_oh),
    .first_idx (pick_idx)
  );

  assign fire      = (st_q == S_ISSUE) && lreq_ready;
  assign op_en     = ((st_q == S_IDLE) && load) || fire;
  assign next_line = {addr_q[LA_W-1:LINE_LSB], {LINE_LSB{1'b0}}} + LA_W'(LINE_BYTES);

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    write_d = write_q;
    cfg_d   = cfg_q;
    size_d  = size_q;
    lanes_d = lanes_q;
    two_d   = two_q;
    data_d  = data_q;
    case (st_q)
      S_IDLE: begin
        if (load) begin
          addr_d  = {addr[LA_W-1:IDX_W], {IDX_W{1'b0}}};
          write_d = kind inside {K_WR, K_WR_INV, K_CFG_WR};
          cfg_d   = kind inside {K_CFG_RD, K_CFG_WR};
          two_d   = (kind == K_RD_TWO);
          lanes_d = write_d ? ~be_n : '0;
          data_d  = wdata;
          if (kind inside {K_RD_LINE, K_RD_TWO})  size_d = SZ_LINE;
          else if (write_d && (be_n != '0))       size_d = SZ_BYTE;
          else                                    size_d = SZ_WORD;
          st_d = (write_d && (&be_n)) ? S_FIN : S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (fire) begin
          if (size_q == SZ_BYTE) begin
            lanes_d = lanes_q & ~pick_oh;
            if (lanes_d == '0) st_d = S_FIN;
          end else if (two_q) begin
            two_d  = 1'b0;
            addr_d = next_line;
          end else begin
            st_d = S_FIN;
          end
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      cfg_q   <= 1'b0;
      size_q  <= SZ_WORD;
      lanes_q <= '0;
      two_q   <= 1'b0;
      data_q  <= '0;
    end else if (op_en) begin
      addr_q  <= addr_d;
      write_q <= write_d;
      cfg_q   <= cfg_d;
      size_q  <= size_d;
      lanes_q <= lanes_d;
      two_q   <= two_d;
      data_q  <= data_d;
    end
  end

  assign lreq_valid = (st_q == S_ISSUE);
  assign lreq_write = write_q;
  assign lreq_cfg   = cfg_q;
  assign lreq_size  = size_q;
  assign lreq_addr  = (size_q == SZ_BYTE) ? {addr_q[LA_W-1:IDX_W], pick_idx} : addr_q;
  assign lreq_data  = (size_q == SZ_BYTE) ? PCI_AW'(data_q[{pick_idx, 3'b000} +: 8]) : data_q;
  assign done       = (st_q == S_FIN);
  assign idle       = (st_q == S_IDLE);

endmodule

// File: rtl/pci_tgt_cmd_handler.sv
module pci_tgt_cmd_handler
  import pci_tgt_pkg::*;
#(
  parameter int PCI_AW     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LA_W       = 2 * PCI_AW,
  parameter int LANES      = PCI_AW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              agent_mode,
  input  logic              cap_valid,
  input  logic [3:0]        cap_cmd,
  input  logic [PCI_AW-1:0] cap_addr,
  input  logic [LANES-1:0]  cap_be_n,
  input  logic [PCI_AW-1:0] cap_wdata,
  input  logic              cap_idsel,
  input  logic              cap_prefetch,
  output logic              claim,
  output logic              ignore,
  output logic              inval_valid,
  output logic [LA_W-1:0]   inval_addr,
  output logic              lreq_valid,
  input  logic              lreq_ready,
  output logic              lreq_write,
  output logic              lreq_cfg,
  output logic [1:0]        lreq_size,
  output logic [LA_W-1:0]   lreq_addr,
  output logic [PCI_AW-1:0] lreq_data,
  output logic              done
);

  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic              rst_s1, rst_sn;
  logic              idle;
  logic              take;
  logic              load;
  kind_e             kind;
  logic              dual_q, dual_d;
  logic [PCI_AW-1:0] low_q, low_d;
  logic [LA_W-1:0]   full_addr;
  logic              claim_d, ignore_d, inval_d;
  logic [LA_W-1:0]   inval_addr_d;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  pci_tgt_cmd_decode u_dec (
    .cmd        (cap_cmd),
    .idsel      (cap_idsel),
    .agent_mode (agent_mode),
    .prefetch   (cap_prefetch),
    .dual_pend  (dual_q),
    .kind       (kind)
  );

  assign take      = cap_valid && idle;
  assign load      = take && (kind != K_IGNORE) && (kind != K_DAC);
  assign full_addr = dual_q ? {cap_addr, low_q} : {{PCI_AW{1'b0}}, cap_addr};

  always_comb begin
    claim_d      = take && (kind != K_IGNORE);
    ignore_d     = take && (kind == K_IGNORE);
    inval_d      = take && (kind == K_WR_INV);
    inval_addr_d = {full_addr[LA_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
    dual_d       = dual_q;
    low_d        = low_q;
    if (take) begin
      dual_d = (kind == K_DAC);
      if (kind == K_DAC) low_d = cap_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      claim       <= 1'b0;
      ignore      <= 1'b0;
      inval_valid <= 1'b0;
    end else begin
      claim       <= claim_d;
      ignore      <= ignore_d;
      inval_valid <= inval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      inval_addr <= '0;
    end else if (inval_d) begin
      inval_addr <= inval_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dual_q <= 1'b0;
      low_q  <= '0;
    end else if (take) begin
      dual_q <= dual_d;
      low_q  <= low_d;
    end
  end

  pci_tgt_req_seq #(
    .PCI_AW     (PCI_AW),
    .LINE_BYTES (LINE_BYTES),
    .LA_W       (LA_W),
    .LANES      (LANES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load       (load),
    .kind       (kind),
    .addr       (full_addr),
    .be_n       (cap_be_n),
    .wdata      (cap_wdata),
    .lreq_ready (lreq_ready),
    .lreq_valid (lreq_valid),
    .lreq_write (lreq_write),
    .lreq_cfg   (lreq_cfg),
    .lreq_size  (lreq_size),
    .lreq_addr  (lreq_addr),
    .lreq_data  (lreq_data),
    .done       (done),
    .idle       (idle)
  );

endmodule

// File: rtl/pci_tgt_cmd_chk.sv
module pci_tgt_cmd_chk #(
  parameter int PCI_AW = 32,
  parameter int LA_W   = 2 * PCI_AW,
  parameter int LANES  = PCI_AW / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              agent_mode,
  input logic              cap_valid,
  input logic [3:0]        cap_cmd,
  input logic              cap_idsel,
  input logic              idle,
  input logic              claim,
  input logic              ignore,
  input logic              lreq_valid,
  input logic              lreq_ready,
  input logic              lreq_write,
  input logic [1:0]        lreq_size,
  input logic [LA_W-1:0]   lreq_addr,
  input logic [PCI_AW-1:0] lreq_data,
  input logic              done
);

  // R1
  reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && idle && (cap_cmd inside {4'b0100, 4'b0101, 4'b1000, 4'b1001}))
      |=> (ignore && !claim));

  // R2
  legacy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && idle && (cap_cmd[3:2] == 2'b00)) |=> (ignore && !claim));

  // R3
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && idle && (cap_cmd[3:1] == 3'b101) && !(agent_mode && cap_idsel))
      |=> (ignore && !claim));

  // R4
  answer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim || ignore) |-> $past(cap_valid && idle));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && !lreq_ready) |=> (lreq_valid && $stable(lreq_addr) &&
      $stable(lreq_data) && $stable(lreq_size) && $stable(lreq_write)));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lreq_valid);

  // R9
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && (lreq_size == 2'd0)) |-> (lreq_write && (lreq_data[PCI_AW-1:8] == '0)));

  // R5
  line_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && (lreq_size == 2'd2)) |-> (!lreq_write && (lreq_addr[1:0] == 2'b00)));

endmodule

bind pci_tgt_cmd_handler pci_tgt_cmd_chk #(
  .PCI_AW (PCI_AW),
  .LA_W   (LA_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .agent_mode (agent_mode),
  .cap_valid  (cap_valid),
  .cap_cmd    (cap_cmd),
  .cap_idsel  (cap_idsel),
  .idle       (idle),
  .claim      (claim),
  .ignore     (ignore),
  .lreq_valid (lreq_valid),
  .lreq_ready (lreq_ready),
  .lreq_write (lreq_write),
  .lreq_size  (lreq_size),
  .lreq_addr  (lreq_addr),
  .lreq_data  (lreq_data),
  .done       (done)
);

// File: tb/test_pci_tgt_cmd_handler.sv
module test_pci_tgt_cmd_handler;

  logic        clk;
  logic        rst_n;
  logic        agent_mode;
  logic        cap_valid;
  logic [3:0]  cap_cmd;
  logic [31:0] cap_addr;
  logic [3:0]  cap_be_n;
  logic [31:0] cap_wdata;
  logic        cap_idsel;
  logic        cap_prefetch;
  logic        claim, ignore, inval_valid;
  logic [63:0] inval_addr;
  logic        lreq_valid, lreq_ready, lreq_write, lreq_cfg;
  logic [1:0]  lreq_size;
  logic [63:0] lreq_addr;
  logic [31:0] lreq_data;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // bench model state
  bit          m_dual = 0;
  logic [31:0] m_low  = '0;
  bit          e_claim;
  bit          e_inval;
  bit          e_dual;
  logic [63:0] e_inval_addr;
  int          e_n;
  logic [63:0] e_addr [4];
  logic [1:0]  e_size [4];
  bit          e_wr   [4];
  bit          e_cfg  [4];
  logic [31:0] e_data [4];
  string       e_tag;

  pci_tgt_cmd_handler i_pci_tgt_cmd_handler (
    .clk, .rst_n, .agent_mode, .cap_valid, .cap_cmd, .cap_addr, .cap_be_n,
    .cap_wdata, .cap_idsel, .cap_prefetch, .claim, .ignore, .inval_valid,
    .inval_addr, .lreq_valid, .lreq_ready, .lreq_write, .lreq_cfg, .lreq_size,
    .lreq_addr, .lreq_data, .done
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add_req(logic [63:0] a, logic [1:0] s, bit w, bit c, logic [31:0] d);
    e_addr[e_n] = a; e_size[e_n] = s; e_wr[e_n] = w; e_cfg[e_n] = c; e_data[e_n] = d;
    e_n++;
  endtask

  task automatic add_write(logic [63:0] wbase, logic [3:0] be_n, logic [31:0] wd, bit c);
    if (be_n == 4'b0000) begin
      add_req(wbase, 2'd1, 1, c, wd);
      e_tag = "R8";
    end else if (be_n == 4'b1111) begin
      e_tag = "R10";
    end else begin
      for (int l = 0; l < 4; l++)
        if (!be_n[l]) add_req(wbase + 64'(l), 2'd0, 1, c, (wd >> (8 * l)) & 32'hFF);
      e_tag = "R9";
    end
  endtask

  task automatic model(logic [3:0] cmd, logic [31:0] a, logic [3:0] be_n,
                       logic [31:0] wd, bit idsel, bit pref, bit agent);
    logic [63:0] full, wbase, lbase;
    full  = m_dual ? {a, m_low} : {32'h0, a};
    wbase = full & ~64'h3;
    lbase = full & ~64'h1F;
    e_claim = 1; e_inval = 0; e_dual = 0; e_n = 0; e_inval_addr = lbase;
    case (cmd)
      4'b0000, 4'b0001, 4'b0010, 4'b0011: begin e_claim = 0; e_tag = "R2"; end
      4'b0100, 4'b0101, 4'b1000, 4'b1001: begin e_claim = 0; e_tag = "R1"; end
      4'b1010: begin
        e_tag = "R3";
        if (agent && idsel) add_req(wbase, 2'd1, 0, 1, 32'h0); else e_claim = 0;
      end
      4'b1011: begin
        if (agent && idsel) add_write(wbase, be_n, wd, 1);
        else begin e_claim = 0; e_tag = "R3"; end
      end
      4'b0110: begin e_tag = "R5"; add_req(wbase, pref ? 2'd2 : 2'd1, 0, 0, 32'h0); end
      4'b1110: begin e_tag = "R6"; add_req(wbase, 2'd2, 0, 0, 32'h0); end
      4'b1100: begin
        e_tag = "R7";
        add_req(wbase, 2'd2, 0, 0, 32'h0);
        add_req(lbase + 64'd32, 2'd2, 0, 0, 32'h0);
      end
      4'b1101: begin
        e_tag = "R13";
        if (m_dual) e_claim = 0; else e_dual = 1;
      end
      4'b0111: add_write(wbase, be_n, wd, 0);
      4'b1111: begin add_write(wbase, be_n, wd, 0); e_inval = 1; end
      default: e_claim = 0;
    endcase
    if (m_dual && cmd != 4'b1101) e_tag = {e_tag, "/R13"};
    m_dual = e_dual;
    if (e_dual) m_low = a;
  endtask

  task automatic run_cmd(logic [3:0] cmd, logic [31:0] a, logic [3:0] be_n,
                         logic [31:0] wd, bit idsel, bit pref, bit agent);
    int  idx;
    bit  got_done;
    bit  r;
    model(cmd, a, be_n, wd, idsel, pref, agent);
    @(negedge clk);
    agent_mode = agent; cap_valid = 1; cap_cmd = cmd; cap_addr = a; cap_be_n = be_n;
    cap_wdata = wd; cap_idsel = idsel; cap_prefetch = pref;
    @(negedge clk);
    cap_valid = 0;
    // R4: one answer, the cycle after the strobe
    check(claim == e_claim && ignore == !e_claim, {e_tag, "/R4"}, "claim/ignore",
          {62'h0, claim, ignore}, {62'h0, e_claim, !e_claim});
    // R12
    check(inval_valid == e_inval, "R12", "inval_valid", 64'(inval_valid), 64'(e_inval));
    if (e_inval) check(inval_addr == e_inval_addr, "R12", "inval_addr", inval_addr, e_inval_addr);
    if (!e_claim || e_dual) begin
      // no request and no completion may follow
      bit quiet = 1;
      for (int c = 0; c < 3; c++) begin
        if (lreq_valid || done) quiet = 0;
        @(negedge clk);
      end
      check(quiet, e_tag, "quiet after ignore/dual", 64'(!quiet), 64'h0);
      return;
    end
    idx = 0;
    got_done = 0;
    for (int c = 0; c < 200 && !got_done; c++) begin
      if (c > 0) @(negedge clk);
      if (done) begin
        check(idx == e_n, {e_tag, "/R11"}, "requests before done", 64'(idx), 64'(e_n));
        got_done = 1;
        lreq_ready = 0;
      end else if (lreq_valid) begin
        r = ($urandom % 4) != 0;
        if (r) begin
          if (idx >= e_n) begin
            check(0, e_tag, "extra request", 64'(idx), 64'(e_n));
          end else begin
            check(lreq_addr == e_addr[idx], e_tag, "lreq_addr", lreq_addr, e_addr[idx]);
            check(lreq_size == e_size[idx], e_tag, "lreq_size", 64'(lreq_size), 64'(e_size[idx]));
            check(lreq_write == e_wr[idx] && lreq_cfg == e_cfg[idx], e_tag, "write/cfg",
                  {62'h0, lreq_write, lreq_cfg}, {62'h0, e_wr[idx], e_cfg[idx]});
            if (e_wr[idx])
              check(lreq_data == e_data[idx], e_tag, "lreq_data", 64'(lreq_data), 64'(e_data[idx]));
          end
          idx++;
        end
        lreq_ready = r;
      end else begin
        lreq_ready = 0;
      end
    end
    if (!got_done) check(0, {e_tag, "/R11"}, "done never seen", 64'h0, 64'h1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0]  cmd;
    logic [3:0]  be;
    void'($urandom(32'd4711));
    rst_n = 0; agent_mode = 0; cap_valid = 0; cap_cmd = '0; cap_addr = '0;
    cap_be_n = '0; cap_wdata = '0; cap_idsel = 0; cap_prefetch = 0; lreq_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R4: idle outputs after reset
    check(!claim && !ignore && !lreq_valid && !done && !inval_valid, "R4", "reset outputs",
          {59'h0, claim, ignore, lreq_valid, done, inval_valid}, 64'h0);

    // directed corner cases
    run_cmd(4'b0100, 32'h1000, 4'h0, 32'h0, 1, 1, 1);          // R1
    run_cmd(4'b0101, 32'h1000, 4'h0, 32'h0, 1, 1, 1);          // R1
    run_cmd(4'b1000, 32'h1000, 4'h0, 32'h0, 1, 1, 1);          // R1
    run_cmd(4'b1001, 32'h1000, 4'h0, 32'h0, 1, 1, 1);          // R1
    run_cmd(4'b0000, 32'h0, 4'h0, 32'h0, 1, 0, 1);             // R2
    run_cmd(4'b0011, 32'h40, 4'h0, 32'h5, 1, 0, 1);            // R2
    run_cmd(4'b1010, 32'h8, 4'h0, 32'h0, 1, 0, 0);             // R3 no agent
    run_cmd(4'b1011, 32'h8, 4'h0, 32'h1, 0, 0, 1);             // R3 no idsel
    run_cmd(4'b1010, 32'h0C, 4'h0, 32'h0, 1, 0, 1);            // R3 claimed
    run_cmd(4'b1011, 32'h10, 4'b1100, 32'hA1B2C3D4, 1, 0, 1);  // R3 + R9
    run_cmd(4'b0110, 32'h2003, 4'h0, 32'h0, 0, 1, 0);          // R5 line
    run_cmd(4'b0110, 32'h2007, 4'h0, 32'h0, 0, 0, 0);          // R5 word
    run_cmd(4'b1110, 32'h3010, 4'h0, 32'h0, 0, 0, 0);          // R6
    run_cmd(4'b1100, 32'h401C, 4'h0, 32'h0, 0, 1, 0);          // R7 near line end
    run_cmd(4'b0111, 32'h5000, 4'b0000, 32'h11223344, 0, 0, 0); // R8
    run_cmd(4'b0111, 32'h5002, 4'b1010, 32'hDEADBEEF, 0, 0, 0); // R9 lanes 0,2
    run_cmd(4'b0111, 32'h5004, 4'b0111, 32'hCAFEF00D, 0, 0, 0); // R9 lane 3 only
    run_cmd(4'b0111, 32'h5008, 4'b1111, 32'h0, 0, 0, 0);       // R10
    run_cmd(4'b1111, 32'h6024, 4'b0000, 32'h55AA55AA, 0, 0, 0); // R12
    run_cmd(4'b1101, 32'h7040, 4'h0, 32'h0, 0, 0, 0);          // R13 low half
    run_cmd(4'b0110, 32'h00000009, 4'h0, 32'h0, 0, 1, 0);      // R13 upper half
    run_cmd(4'b1101, 32'h7080, 4'h0, 32'h0, 0, 0, 0);          // R13
    run_cmd(4'b1101, 32'h1, 4'h0, 32'h0, 0, 0, 0);             // R13 second dual ignored
    run_cmd(4'b1110, 32'h100, 4'h0, 32'h0, 0, 0, 0);           // R13 pending cleared

    // constrained random
    for (int i = 0; i < 400; i++) begin
      cmd = 4'($urandom);
      be  = (($urandom % 3) == 0) ? 4'h0 : 4'($urandom);
      run_cmd(cmd, $urandom, be, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule